// File: doc/BRIEF.md
# USB NRZI Packet Serialiser

This block turns a stream of bytes into one low-speed or full-speed USB packet on the differential pair. It advances one bit per `bit_en` strobe. Every packet opens with the fixed sync field. The payload follows least significant bit first. A zero is inserted after every run of six ones, and the run count carries across byte edges. The line is NRZI coded: a 0 moves the pair between J and K, and a 1 leaves it where it is. The packet closes with end-of-packet, after which the block stops driving the pair.

Bytes arrive on a valid/ready/last handshake. The block takes a byte on the strobe that sends that byte's first bit, so consecutive bytes leave without any gap in bit timing. `full_speed` chooses which wire is high in the J state. CRC, PID formation and the analogue drivers belong to other blocks.

Top module: `usb_pkt_serializer`

## Requirements
- R1: After reset, `line_oe` is 0, the pair shows J and `in_ready` is 0. Strobes that arrive while `in_valid` is low leave the block idle.
- R2: A strobe that finds the block idle with `in_valid` high starts a packet. That strobe and the next seven send sync bits 0,0,0,0,0,0,0,1, which show on the pair as K J K J K J K K.
- R3: Every sync, data or stuffed bit is NRZI coded. A 0 changes the line to the other of J/K, and a 1 keeps the previous level.
- R4: Data bits are sent bit 0 first. A byte is taken (`in_ready` and `in_valid` both high) on the strobe that sends its bit 0. The bit 0 of the next byte directly follows bit 7 of the previous byte, or the stuffed bit that comes between them.
- R5: After six consecutive 1 bits, the next bit period carries a stuffed 0. The run count includes the final sync 1, runs across byte boundaries, and restarts on any 0, including a stuffed one.
- R6: `in_ready` is high only during a strobe cycle. It is low during any strobe cycle that sends a stuffed bit.
- R7: If the final data bit completes a run of six ones, the stuffed 0 is sent before end-of-packet begins.
- R8: End-of-packet is two bit periods of SE0 (both wires low) followed by one bit period of J, all with `line_oe` high. The following strobe drops `line_oe`. SE0 never appears while `line_oe` is low.
- R9: With `full_speed`=1, J is dp=1,dm=0 and K is dp=0,dm=1. With `full_speed`=0 the two are swapped. SE0 is dp=0,dm=0. While the pair is not driven it shows J.
- R10: If `in_valid` is low on a strobe that needs the next byte, the packet ends there. Any pending stuffed 0 goes first, then the R8 end-of-packet.
- R11: `dp_out`, `dm_out` and `line_oe` change only on clock edges that carry `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| full_speed | input | 1 | 1 selects full-speed J polarity, 0 low-speed |
| in_data | input | BYTE_W | Byte to send |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The presented byte is the final one of the packet |
| in_ready | output | 1 | The presented byte is taken on this edge |
| dp_out | output | 1 | Positive data wire level |
| dm_out | output | 1 | Negative data wire level |
| line_oe | output | 1 | Pair is driven |

## Verification
Two events can claim the same bit period. A stuffed zero can collide with loading the next byte, and it can also collide with the start of end-of-packet. When that happens the stuffed bit must win, and the handshake or the SE0 slips one period. Runs of 0xFF placed across byte edges provoke the first collision, and payloads that end in six ones (with a normal last byte or with a source underrun) provoke the second. The bench judges each packet by comparing the captured pair sequence and the strobes where bytes were taken against a bit-level model that it builds from the requirements.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2
  } line_sym_t;

  typedef enum logic [1:0] {
    CMD_BIT     = 2'd0,
    CMD_SE0     = 2'd1,
    CMD_EOPJ    = 2'd2,
    CMD_RELEASE = 2'd3
  } line_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_DATA = 3'd2,
    ST_TAIL = 3'd3,
    ST_SE0  = 3'd4,
    ST_EOPJ = 3'd5,
    ST_REL  = 3'd6
  } seq_state_t;

  // Sync field: zeros, closed by a single one in the final position.
  function automatic logic sync_bit(input int idx, input int len);
    return (idx == len - 1);
  endfunction

  // NRZI: a zero moves to the opposite data level, a one holds.
  function automatic line_sym_t nrzi_next(input line_sym_t lvl, input logic b);
    if (b) return lvl;
    return (lvl == SYM_J) ? SYM_K : SYM_J;
  endfunction

  // Wire pair {dp, dm} for a symbol under the chosen speed polarity.
  function automatic logic [1:0] pair_of(input line_sym_t s, input logic full);
    case (s)
      SYM_SE0: return 2'b00;
      SYM_J:   return full ? 2'b10 : 2'b01;
      default: return full ? 2'b01 : 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/usb_tx_stuffer.sv
module usb_tx_stuffer #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic bit_val,
  input  logic clear,
  output logic stuff_due
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (clear)    run_q <= '0;
    else if (count_en) run_q <= bit_val ? run_q + CW'(1) : '0;
  end

  assign stuff_due = (run_q == RUN_MAX);

  // R5: the run of ones never goes past the stuffing limit
  assert_run_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);

  // R5: the bit sent when a stuff is due is a zero
  assert_stuff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_due && count_en) |-> !bit_val);

endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  line_cmd_t cmd,
  input  logic      bit_val,
  output line_sym_t sym_q,
  output logic      oe_q
);
  line_sym_t lvl_q;
  logic      flip_evt;
  logic      keep_evt;

  assign flip_evt = step && (cmd == CMD_BIT) && !bit_val;
  assign keep_evt = step && (cmd == CMD_BIT) && bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= SYM_J;
      sym_q <= SYM_J;
      oe_q  <= 1'b0;
    end else if (step) begin
      case (cmd)
        CMD_BIT: begin
          lvl_q <= nrzi_next(lvl_q, bit_val);
          sym_q <= nrzi_next(lvl_q, bit_val);
          oe_q  <= 1'b1;
        end
        CMD_SE0: begin
          sym_q <= SYM_SE0;
          oe_q  <= 1'b1;
        end
        CMD_EOPJ: begin
          lvl_q <= SYM_J;
          sym_q <= SYM_J;
          oe_q  <= 1'b1;
        end
        default: begin
          lvl_q <= SYM_J;
          sym_q <= SYM_J;
          oe_q  <= 1'b0;
        end
      endcase
    end
  end

  // R11: no strobe, no change on the line
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(sym_q) && $stable(oe_q)));

  // R3: a zero bit lands on the other data level
  assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> (sym_q != $past(lvl_q)));

  // R3: a one bit keeps the data level
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    keep_evt |=> (sym_q == $past(lvl_q)));

endmodule

// File: rtl/usb_tx_seq.sv
module usb_tx_seq
  import usb_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_LEN    = 8,
  parameter int EOP_SE0_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              stuff_due,
  output logic              in_ready,
  output logic              step,
  output line_cmd_t         cmd,
  output logic              bit_val,
  output logic              stuff_slot
);
  localparam int CNT_MAX = (SYNC_LEN > EOP_SE0_LEN) ? SYNC_LEN : EOP_SE0_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN - 1);
  localparam logic [CNT_W-1:0] SE0_END  = CNT_W'(EOP_SE0_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(BYTE_W - 1);

  seq_state_t        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              last_q, last_n;
  logic              load_q, load_n;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    idx_n      = idx_q;
    last_n     = last_q;
    load_n     = load_q;
    step       = 1'b0;
    cmd        = CMD_BIT;
    bit_val    = 1'b0;
    in_ready   = 1'b0;
    stuff_slot = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (bit_en && in_valid) begin
          step    = 1'b1;
          bit_val = sync_bit(0, SYNC_LEN);
          cnt_n   = CNT_W'(1);
          state_n = ST_SYNC;
        end
      end
      ST_SYNC: begin
        if (bit_en) begin
          step    = 1'b1;
          bit_val = sync_bit(int'(cnt_q), SYNC_LEN);
          cnt_n   = cnt_q + CNT_W'(1);
          if (cnt_q == SYNC_END) begin
            state_n = ST_DATA;
            load_n  = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bit_en) begin
          step = 1'b1;
          if (stuff_due) begin
            stuff_slot = 1'b1;
          end else if (load_q) begin
            in_ready = 1'b1;
            load_n   = 1'b0;
            if (in_valid) begin
              bit_val = in_data[0];
              sh_n    = in_data[BYTE_W-1:1];
              idx_n   = IDX_W'(1);
              last_n  = in_last;
            end else begin
              cmd     = CMD_SE0;
              cnt_n   = CNT_W'(1);
              state_n = ST_SE0;
            end
          end else begin
            bit_val = sh_q[0];
            sh_n    = sh_q >> 1;
            idx_n   = idx_q + IDX_W'(1);
            if (idx_q == IDX_END) begin
              if (last_q) state_n = ST_TAIL;
              else        load_n  = 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (bit_en) begin
          step = 1'b1;
          if (stuff_due) begin
            stuff_slot = 1'b1;
          end else begin
            cmd     = CMD_SE0;
            cnt_n   = CNT_W'(1);
            state_n = ST_SE0;
          end
        end
      end
      ST_SE0: begin
        if (bit_en) begin
          step  = 1'b1;
          cmd   = CMD_SE0;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == SE0_END) state_n = ST_EOPJ;
        end
      end
      ST_EOPJ: begin
        if (bit_en) begin
          step    = 1'b1;
          cmd     = CMD_EOPJ;
          state_n = ST_REL;
        end
      end
      ST_REL: begin
        if (bit_en) begin
          step    = 1'b1;
          cmd     = CMD_RELEASE;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      idx_q   <= idx_n;
      last_q  <= last_n;
      load_q  <= load_n;
    end
  end

  // R6: a byte is only offered on a strobe that carries no stuffed bit
  assert_ready_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && !stuff_due));

  // R8: the closing J is reached only from the SE0 run
  assert_eopj_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EOPJ && $past(state_q) != ST_EOPJ) |-> ($past(state_q) == ST_SE0));

  // R7: no byte is offered once the last byte has been sent
  assert_tail_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> !in_ready);

endmodule

// File: rtl/usb_pkt_serializer.sv
module usb_pkt_serializer
  import usb_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_LEN    = 8,
  parameter int STUFF_RUN   = 6,
  parameter int EOP_SE0_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              full_speed,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              dp_out,
  output logic              dm_out,
  output logic              line_oe
);
  logic      step;
  line_cmd_t cmd;
  logic      bit_val;
  logic      stuff_due;
  logic      stuff_slot;
  logic      count_en;
  logic      run_clear;
  line_sym_t sym;
  logic      oe;

  assign count_en  = step && (cmd == CMD_BIT);
  assign run_clear = step && (cmd == CMD_RELEASE);

  usb_tx_seq #(
    .BYTE_W      (BYTE_W),
    .SYNC_LEN    (SYNC_LEN),
    .EOP_SE0_LEN (EOP_SE0_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .stuff_due  (stuff_due),
    .in_ready   (in_ready),
    .step       (step),
    .cmd        (cmd),
    .bit_val    (bit_val),
    .stuff_slot (stuff_slot)
  );

  usb_tx_stuffer #(
    .RUN (STUFF_RUN)
  ) u_stuffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .bit_val   (bit_val),
    .clear     (run_clear),
    .stuff_due (stuff_due)
  );

  usb_tx_line u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .cmd     (cmd),
    .bit_val (bit_val),
    .sym_q   (sym),
    .oe_q    (oe)
  );

  assign {dp_out, dm_out} = pair_of(sym, full_speed);
  assign line_oe          = oe;

  // R8: SE0 is only ever driven, never left floating
  assert_se0_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_out && !dm_out) |-> line_oe);

  // R6: a stuffed slot and a byte hand-off never share a strobe
  assert_stuff_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_slot |-> !in_ready);

endmodule

// File: tb/usb_pkt_serializer_bench.sv
`timescale 1ns/1ps
module usb_pkt_serializer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       full_speed = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       dp_out;
  logic       dm_out;
  logic       line_oe;

  always #2.5 clk = ~clk;

  usb_pkt_serializer u_usb_pkt_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .full_speed (full_speed),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .dp_out     (dp_out),
    .dm_out     (dm_out),
    .line_oe    (line_oe)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] pk [0:15];
  logic [2:0] exp_sym  [0:255];
  bit         exp_xfer [0:255];
  bit         exp_stf  [0:255];
  int         exp_len;
  logic [2:0] cap_sym  [0:255];
  bit         cap_xfer [0:255];
  bit         cap_rdy  [0:255];
  int         cap_len;

  int m_lvl, m_ones, m_k;
  bit m_full;

  // {oe, dp, dm}: 0=J, 1=K, 2=SE0, 3=released
  function automatic logic [2:0] enc(input int s, input bit full);
    case (s)
      0:       return full ? 3'b110 : 3'b101;
      1:       return full ? 3'b101 : 3'b110;
      2:       return 3'b100;
      default: return full ? 3'b010 : 3'b001;
    endcase
  endfunction

  task automatic emit(input bit b, input bit x, input bit s);
    if (!b) m_lvl = 1 - m_lvl;
    m_ones = b ? m_ones + 1 : 0;
    exp_sym[m_k]  = enc(m_lvl, m_full);
    exp_xfer[m_k] = x;
    exp_stf[m_k]  = s;
    m_k++;
  endtask

  task automatic emit_fixed(input int s);
    exp_sym[m_k]  = enc(s, m_full);
    exp_xfer[m_k] = 1'b0;
    exp_stf[m_k]  = 1'b0;
    m_k++;
  endtask

  task automatic build_expected(input int n, input bit full);
    m_k = 0; m_lvl = 0; m_ones = 0; m_full = full;
    for (int i = 0; i < 8; i++) emit(i == 7, 1'b0, 1'b0);
    for (int j = 0; j < n; j++) begin
      for (int i = 0; i < 8; i++) begin
        if (m_ones == 6) emit(1'b0, 1'b0, 1'b1);
        emit(pk[j][i], i == 0, 1'b0);
      end
    end
    if (m_ones == 6) emit(1'b0, 1'b0, 1'b1);
    emit_fixed(2); emit_fixed(2); emit_fixed(0); emit_fixed(3);
    exp_len = m_k;
  endtask

  function automatic string region_tag(input int k);
    if (k < 8)            return "R2";
    if (k >= exp_len - 4) return "R8";
    if (exp_stf[k])       return "R5";
    return "R3";
  endfunction

  task automatic check_eq(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_packet(input int n, input bit full, input bit under, input string tag);
    int idx = 0;
    int cyc = 0;
    int budget = 0;
    int stab_err = 0;
    int bad = -1;
    int badx = -1;
    int stf_rdy = 0;
    bit started = 0, done = 0, prev_strobe = 0, prev_rdy = 0, prev_valid = 0;
    logic [2:0] out, last_out;
    full_speed = full;
    build_expected(n, full);
    cap_len = 0;
    last_out = 3'b000;
    while (!done && budget < 4000) begin
      @(negedge clk);
      budget++;
      out = {line_oe, dp_out, dm_out};
      if (prev_strobe) begin
        if (started || out[2]) begin
          started = 1;
          if (cap_len < 256) begin
            cap_sym[cap_len]  = out;
            cap_rdy[cap_len]  = prev_rdy;
            cap_xfer[cap_len] = prev_rdy && prev_valid;
            cap_len++;
          end
          if (!out[2]) done = 1;
        end
      end else if (started && out !== last_out) begin
        stab_err++;
      end
      last_out = out;
      if (prev_rdy && prev_valid) idx++;
      if (!done) begin
        bit_en   = (cyc % 4 == 0);
        cyc++;
        in_valid = (idx < n);
        in_last  = !under && (idx == n - 1);
        in_data  = (idx < n) ? pk[idx] : 8'h00;
      end else begin
        bit_en = 0; in_valid = 0; in_last = 0;
      end
      #1;
      prev_rdy    = in_ready;
      prev_valid  = in_valid;
      prev_strobe = bit_en;
    end
    bit_en = 0; in_valid = 0; in_last = 0;
    check_eq(int'(done), 1, {tag, " R8"}, "packet reached release");
    check_eq(cap_len, exp_len, {tag, " R8"}, "bit periods from start to release");
    for (int k = 0; k < exp_len && k < cap_len; k++) begin
      if (bad < 0 && cap_sym[k] !== exp_sym[k]) bad = k;
      if (badx < 0 && cap_xfer[k] !== exp_xfer[k]) badx = k;
      if (exp_stf[k] && cap_rdy[k]) stf_rdy++;
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s %s line at bit %0d: actual %b expected %b",
               tag, region_tag(bad), bad, cap_sym[bad], exp_sym[bad]);
    end
    checks++;
    if (badx >= 0) begin
      fails++;
      $display("FAIL %s R4 byte take at bit %0d: actual %0d expected %0d",
               tag, badx, cap_xfer[badx], exp_xfer[badx]);
    end
    check_eq(stf_rdy, 0, {tag, " R6"}, "ready during stuffed bits");
    check_eq(stab_err, 0, {tag, " R11"}, "line changes off strobe");
    check_eq(idx, n, {tag, " R4 R10"}, "bytes taken");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8: actual hung expected finished run");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd9157);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq(int'(line_oe), 0, "R1", "oe after reset");
    check_eq(int'({dp_out, dm_out}), 2, "R1", "pair after reset");
    check_eq(int'(in_ready), 0, "R1", "ready after reset");
    for (int c = 0; c < 12; c++) begin
      bit_en = (c % 4 == 0);
      #1;
      if (bit_en) check_eq(int'(in_ready), 0, "R1", "ready idle strobe");
      @(negedge clk);
    end
    bit_en = 1'b0;
    check_eq(int'(line_oe), 0, "R1", "oe stays low without valid");
    full_speed = 1'b0;
    #1;
    check_eq(int'({dp_out, dm_out}), 1, "R9", "low-speed idle pair");
    full_speed = 1'b1;
    @(negedge clk);

    pk[0] = 8'hA5; pk[1] = 8'h3C;
    run_packet(2, 1'b1, 1'b0, "R4");
    pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'hFF;
    run_packet(3, 1'b1, 1'b0, "R5");
    pk[0] = 8'h00; pk[1] = 8'hFC;
    run_packet(2, 1'b1, 1'b0, "R7");
    pk[0] = 8'h7F; pk[1] = 8'h81;
    run_packet(2, 1'b0, 1'b0, "R9");
    pk[0] = 8'h12; pk[1] = 8'hFC;
    run_packet(2, 1'b1, 1'b1, "R10");
    pk[0] = 8'hFF;
    run_packet(1, 1'b1, 1'b0, "R5");

    for (int p = 0; p < 20; p++) begin
      int n;
      bit fs, un;
      n  = 1 + int'($urandom % 6);
      fs = bit'($urandom % 2);
      un = ($urandom % 4) == 0;
      for (int j = 0; j < n; j++)
        pk[j] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      run_packet(n, fs, un, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule